// File: doc/BRIEF.md
# Bit-Slice Four-Bit ALU

This block is a small arithmetic/logic unit assembled from identical one-bit slices. Each slice holds three parts: a bitwise logic function, an operand conditioner that reshapes its A and B bits, and a full adder. A mode bit picks between the logic output and the adder sum. The carries ripple from the least significant slice to the most significant one, starting from the external carry-in.

The arithmetic operation set is not decoded from an opcode. It comes from the way each slice conditions its operand bits before they reach the adder. The result is registered, so the outputs follow the inputs one clock later.

The unit reports the adder's final carry and a two's-complement overflow flag. Overflow is the XOR of the carry into the top slice and the carry out of it. Both flags read zero whenever the unit is in logic mode.

Top module: `bitslice_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `carry_out` and `ovf` become 0 after that edge.
- R2: Outputs change only at a rising edge of `clk`. After each edge they reflect the inputs sampled at that edge, which is a latency of one cycle.
- R3: With `arith_mode`=0, the `sel` encoding gives bitwise operations on `opd_a` and `opd_b`: 2'b00 is AND, 2'b01 is OR, 2'b10 is XOR and 2'b11 is XNOR.
- R4: With `arith_mode`=0, `cin` has no effect on `result`.
- R5: With `arith_mode`=0, `carry_out` and `ovf` are 0.
- R6: With `arith_mode`=1 and `sel`=2'b00, `result` is A when `cin`=0 and A+1 when `cin`=1.
- R7: With `arith_mode`=1 and `sel`=2'b01, `result` is A+B when `cin`=0 and A+B+1 when `cin`=1.
- R8: With `arith_mode`=1 and `sel`=2'b10, `result` is A plus the one's complement of B when `cin`=0, and A−B when `cin`=1.
- R9: With `arith_mode`=1 and `sel`=2'b11, `result` is the one's complement of A plus B when `cin`=0, and B−A when `cin`=1.
- R10: In arithmetic mode, `carry_out` is bit 4 of the 5-bit unsigned sum X+Y+`cin`. Here X and Y are the conditioned operands named in R6 to R9, and 0 stands in for B under `sel`=2'b00.
- R11: In arithmetic mode, `ovf` is 1 exactly when X and Y have the same sign bit and the sign bit of the 4-bit result differs from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opd_a | input | W (4) | Operand A, two's complement |
| opd_b | input | W (4) | Operand B, two's complement |
| arith_mode | input | 1 | 0 selects logic, 1 selects arithmetic |
| sel | input | 2 | Operation select within the mode |
| cin | input | 1 | Carry into the lowest slice |
| result | output | W (4) | Registered result |
| carry_out | output | 1 | Registered carry out of the top slice |
| ovf | output | 1 | Registered two's-complement overflow |

## Verification
On every cycle, the assertions check several properties. The flags are cleared in logic mode. The AND and XNOR results match the operands of the previous cycle. The transfer operation passes A through without overflow. Subtracting equal operands yields zero with a carry. Two things only the bench's scenarios can show: that the complete operation table holds for every operand pair with both carry-in values, and that overflow and carry agree with an arithmetic reference across all sign combinations. The one-cycle latency and the reset value are likewise shown by directed stimulus in the bench.

// File: rtl/bsalu_pkg.sv
`timescale 1ns/1ps
package bsalu_pkg;
  typedef enum logic [1:0] {
    LOG_AND  = 2'b00,
    LOG_OR   = 2'b01,
    LOG_XOR  = 2'b10,
    LOG_XNOR = 2'b11
  } logic_op_e;
endpackage

// File: rtl/bsalu_precond.sv
`timescale 1ns/1ps
// Operand conditioning ahead of the adder in one slice.
module bsalu_precond (
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic [1:0] sel,
  output logic       x_bit,
  output logic       y_bit
);
  always_comb begin
    x_bit = a_bit ^ (sel[1] & sel[0]);
    y_bit = (sel[0] & b_bit) | (sel[1] & ~sel[0] & ~b_bit);
  end
endmodule

// File: rtl/bsalu_logic.sv
`timescale 1ns/1ps
// Bitwise logic function for one slice.
module bsalu_logic
  import bsalu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic [1:0] sel,
  output logic       l_bit
);
  always_comb begin
    unique case (logic_op_e'(sel))
      LOG_AND:  l_bit = a_bit & b_bit;
      LOG_OR:   l_bit = a_bit | b_bit;
      LOG_XOR:  l_bit = a_bit ^ b_bit;
      default:  l_bit = ~(a_bit ^ b_bit);
    endcase
  end
endmodule

// File: rtl/bsalu_slice.sv
`timescale 1ns/1ps
// One bit of the ALU: conditioner, full adder, logic unit and mode mux.
module bsalu_slice (
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       arith_mode,
  input  logic [1:0] sel,
  input  logic       c_in,
  output logic       f_bit,
  output logic       c_out
);
  logic x_bit, y_bit, l_bit, p_bit, s_bit;

  bsalu_precond u_pre (
    .a_bit(a_bit), .b_bit(b_bit), .sel(sel), .x_bit(x_bit), .y_bit(y_bit)
  );

  bsalu_logic u_log (
    .a_bit(a_bit), .b_bit(b_bit), .sel(sel), .l_bit(l_bit)
  );

  always_comb begin
    p_bit = x_bit ^ y_bit;
    s_bit = p_bit ^ c_in;
    c_out = (x_bit & y_bit) | (p_bit & c_in);
    f_bit = arith_mode ? s_bit : l_bit;
  end
endmodule

// File: rtl/bitslice_alu.sv
`timescale 1ns/1ps
// Bit-slice ALU with registered outputs.
module bitslice_alu #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic         arith_mode,
  input  logic [1:0]   sel,
  input  logic         cin,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf
);
  localparam int TOP = W - 1;

  logic [W:0]   chain;
  logic [W-1:0] f_comb;
  logic         cout_comb, ovf_comb;

  assign chain[0] = cin;

  for (genvar gi = 0; gi < W; gi++) begin : g_slice
    bsalu_slice u_slice (
      .a_bit(opd_a[gi]),
      .b_bit(opd_b[gi]),
      .arith_mode(arith_mode),
      .sel(sel),
      .c_in(chain[gi]),
      .f_bit(f_comb[gi]),
      .c_out(chain[gi+1])
    );
  end

  always_comb begin
    cout_comb = arith_mode & chain[W];
    ovf_comb  = arith_mode & (chain[W] ^ chain[TOP]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      result    <= f_comb;
      carry_out <= cout_comb;
      ovf       <= ovf_comb;
    end
  end
endmodule

// File: rtl/bsalu_checker.sv
`timescale 1ns/1ps
module bsalu_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opd_a,
  input logic [W-1:0] opd_b,
  input logic         arith_mode,
  input logic [1:0]   sel,
  input logic         cin,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         ovf
);
  AST_LOGIC_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
    !arith_mode |=> (!carry_out && !ovf)); // R5

  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!arith_mode && sel == 2'b00) |=> result == ($past(opd_a) & $past(opd_b))); // R3

  AST_XNOR_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!arith_mode && sel == 2'b11) |=> result == ~($past(opd_a) ^ $past(opd_b))); // R3

  AST_TRANSFER_A: assert property (@(posedge clk) disable iff (rst)
    (arith_mode && sel == 2'b00 && !cin) |=> (result == $past(opd_a) && !ovf && !carry_out)); // R6

  AST_SUB_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (arith_mode && sel == 2'b10 && cin && opd_a == opd_b) |=> (result == '0 && carry_out && !ovf)); // R8
endmodule

bind bitslice_alu bsalu_checker #(.W(W)) u_bsalu_chk (
  .clk(clk), .rst(rst), .opd_a(opd_a), .opd_b(opd_b),
  .arith_mode(arith_mode), .sel(sel), .cin(cin),
  .result(result), .carry_out(carry_out), .ovf(ovf)
);

// File: tb/test_bitslice_alu.sv
`timescale 1ns/1ps
module test_bitslice_alu;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opd_a = '0, opd_b = '0;
  logic         arith_mode = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic         cin = 1'b0;
  logic [W-1:0] result;
  logic         carry_out, ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  bitslice_alu #(.W(W)) i_bitslice_alu (
    .clk(clk), .rst(rst), .opd_a(opd_a), .opd_b(opd_b),
    .arith_mode(arith_mode), .sel(sel), .cin(cin),
    .result(result), .carry_out(carry_out), .ovf(ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (mode=%0b sel=%0d cin=%0b a=%0d b=%0d)",
               tag, act, exp, arith_mode, sel, cin, opd_a, opd_b);
    end
  endtask

  // Returns {ovf, carry, result} computed from the operation table.
  function automatic logic [W+1:0] model(input logic m, input logic [1:0] s,
                                         input logic c, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [W-1:0] xv, yv, r;
    logic [W:0]   sum;
    logic         v;
    if (!m) begin
      case (s)
        2'b00: r = a & b;
        2'b01: r = a | b;
        2'b10: r = a ^ b;
        default: r = ~(a ^ b);
      endcase
      return {2'b00, r};
    end
    xv = (s == 2'b11) ? ~a : a;
    case (s)
      2'b00: yv = '0;
      2'b10: yv = ~b;
      default: yv = b;
    endcase
    sum = {1'b0, xv} + {1'b0, yv} + {{W{1'b0}}, c};
    v = (xv[W-1] == yv[W-1]) && (sum[W-1] != xv[W-1]);
    return {v, sum[W], sum[W-1:0]};
  endfunction

  task automatic drive(input logic m, input logic [1:0] s, input logic c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    arith_mode = m; sel = s; cin = c; opd_a = a; opd_b = b;
  endtask

  initial begin
    logic [W+1:0] e;
    string rtag;
    // R1: reset clears outputs even with busy inputs
    drive(1'b1, 2'b01, 1'b1, 4'd7, 4'd6);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 result", result, 0);
    check("R1 carry_out", carry_out, 0);
    check("R1 ovf", ovf, 0);

    // R2: output holds until the next edge, then shows the new inputs
    drive(1'b1, 2'b01, 1'b0, 4'd3, 4'd4);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R2 after edge", result, 7);
    drive(1'b1, 2'b01, 1'b0, 4'd1, 4'd1);
    #0.5;
    check("R2 held before edge", result, 7);
    @(posedge clk); #1;
    check("R2 next edge", result, 2);

    // Exhaustive sweep over mode, select, carry-in and operands
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              drive(m[0], s[1:0], c[0], a[W-1:0], b[W-1:0]);
              @(posedge clk); #1;
              e = model(m[0], s[1:0], c[0], a[W-1:0], b[W-1:0]);
              if (m == 0) rtag = (c == 1) ? "R4 cin ignored" : "R3 logic";
              else if (s == 0) rtag = "R6 transfer/increment";
              else if (s == 1) rtag = "R7 add";
              else if (s == 2) rtag = "R8 A+~B / A-B";
              else rtag = "R9 ~A+B / B-A";
              check(rtag, result, e[W-1:0]);
              check(m == 0 ? "R5 carry_out" : "R10 carry_out", carry_out, e[W]);
              check(m == 0 ? "R5 ovf" : "R11 ovf", ovf, e[W+1]);
            end

    // Named corners: most negative operands
    drive(1'b1, 2'b01, 1'b0, 4'b1000, 4'b1000);
    @(posedge clk); #1;
    check("R11 -8+-8 ovf", ovf, 1);
    check("R10 -8+-8 carry", carry_out, 1);
    drive(1'b1, 2'b11, 1'b1, 4'b0001, 4'b1000);
    @(posedge clk); #1;
    check("R9 -8-1 result", result, 7);
    check("R11 -8-1 ovf", ovf, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule